// File: doc/BRIEF.md
# Lockable Set-Associative Data Cache with Per-Line Write Policy

This block is a small set-associative data cache controller. It sits between a load/store port that moves 128-bit beats and a simple request/acknowledge memory bus of the same width. Every access carries a write-policy attribute. When a miss allocates a line, that attribute is stored with the line's valid and dirty bits. From then on the line behaves as write-through or write-back, whatever attribute later accesses carry.

Two configuration inputs make timing predictable. `cfg_disable` sends every access straight to memory and leaves the arrays alone. `cfg_lock` freezes the contents: hits are served as usual, but a miss is forwarded to memory for a single beat and never allocates or evicts a line. Both inputs are sampled when a request is accepted.

The beat address splits as follows. Bit 0 is the beat within a two-beat line. Bits [2:1] are the set index (four sets). Bits [9:3] are the tag. Each set has two ways.

The controller is one state machine:
- IDLE goes to LOOKUP when a request arrives.
- LOOKUP goes to one of these states:
  - MEMWR or MEMRD on a bypass, a locked miss, or a write hit to a write-through line (MEMWR).
  - DONE on any other hit.
  - WBACK on a miss whose victim is dirty.
  - FILL on a miss whose victim is clean or invalid.
- WBACK goes to FILL after its last beat.
- FILL goes back to LOOKUP after its last beat, so the retried access now hits.
- MEMWR and MEMRD go to DONE on acknowledge.
- DONE returns to IDLE.

Top module: `lkc_cache`

## Requirements
- R1: With `cfg_disable` high at acceptance, a read costs exactly one memory read and a write exactly one memory write of that beat, and no tag, state or data entry changes; a later enabled read of the same address therefore misses.
- R2: A write hit to a write-through line updates the array and issues exactly one memory write of the beat; the line stays clean, so evicting it later issues no memory write.
- R3: A write hit to a write-back line updates only the array (no bus traffic) and marks the line dirty; memory keeps its old value until eviction.
- R4: The policy bit stored for a line (1 = write-through) is the `cpu_wt` value of the access that allocated it; the attribute carried by later hits is ignored.
- R5: A miss whose victim is valid and dirty first writes both beats of the victim to memory, beat 0 then beat 1, and only then issues the refill reads.
- R6: With `cfg_lock` high at acceptance, hits behave normally, a read miss is served by one memory read, a write miss by one memory write, and no line is allocated or evicted.
- R7: The victim is the lowest-numbered invalid way, or else the set's round-robin pointer; the pointer moves to the way after the one allocated, and only on allocation (never while locked).
- R8: `cpu_ready` is a one-cycle pulse; during it `cpu_rdata` carries the full 128-bit read beat; `cpu_req` is held until that pulse.
- R9: Once `mem_req` is raised, it, `mem_addr` and `mem_we` stay unchanged until the cycle `mem_ack` is seen.
- R10: After reset every line is invalid, `cpu_ready` and `mem_req` are low, and every round-robin pointer is way 0.
- R11: An unlocked, enabled miss (read or write) fills the whole two-beat line from memory, then completes the access as a hit under the stored policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_disable | input | 1 | Bypass the arrays for the accepted access |
| cfg_lock | input | 1 | Freeze contents for the accepted access |
| cpu_req | input | 1 | Access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_wt | input | 1 | Policy attribute, 1 = write-through |
| cpu_addr | input | 10 | Beat address |
| cpu_wdata | input | 128 | Store data |
| cpu_ready | output | 1 | Access complete (one-cycle pulse) |
| cpu_rdata | output | 128 | Load data, valid with `cpu_ready` |
| mem_req | output | 1 | Memory bus request |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | 10 | Memory beat address |
| mem_wdata | output | 128 | Memory write data |
| mem_ack | input | 1 | Memory beat done |
| mem_rdata | input | 128 | Memory read data, valid with `mem_ack` |

## Verification
The assertions check the following on every cycle:
- a bypassed access never writes an array;
- a locked access never installs a tag and never enters WBACK or FILL;
- FILL is only ever entered straight from LOOKUP when the victim is clean;
- the ready pulse lasts one cycle;
- the bus request stays stable until it is acknowledged.

Only the directed scenarios can show the rest. They compare every load with a flat memory model, count memory reads and writes per access, and check the order of writeback and refill beats. That is how they show which way round-robin evicts, that stored policy bits override later attributes, and that lines stay intact across lock and disable.

// File: rtl/lkc_pkg.sv
package lkc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WBACK,
        ST_FILL,
        ST_MEMWR,
        ST_MEMRD,
        ST_DONE
    } lkc_state_e;
endpackage

// File: rtl/lkc_tags.sv
module lkc_tags #(
    parameter int SETS  = 4,
    parameter int WAYS  = 2,
    parameter int TAG_W = 7
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [$clog2(SETS)-1:0]       rd_set,
    input  logic [TAG_W-1:0]              cmp_tag,
    output logic                          hit,
    output logic [$clog2(WAYS)-1:0]       hit_way,
    output logic [WAYS-1:0]               way_valid,
    output logic [WAYS-1:0]               way_dirty,
    output logic [WAYS-1:0]               way_wt,
    output logic [WAYS-1:0][TAG_W-1:0]    way_tag,
    input  logic                          inst_en,
    input  logic [$clog2(SETS)-1:0]       inst_set,
    input  logic [$clog2(WAYS)-1:0]       inst_way,
    input  logic [TAG_W-1:0]              inst_tag,
    input  logic                          inst_wt,
    input  logic                          dirty_en,
    input  logic [$clog2(SETS)-1:0]       dirty_set,
    input  logic [$clog2(WAYS)-1:0]       dirty_way
);
    localparam int WAY_BITS = $clog2(WAYS);

    logic [WAYS-1:0]  valid_r [SETS];
    logic [WAYS-1:0]  dirty_r [SETS];
    logic [WAYS-1:0]  wt_r    [SETS];
    logic [TAG_W-1:0] tag_r   [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_r[s] <= '0;
                dirty_r[s] <= '0;
                wt_r[s]    <= '0;
            end
        end else begin
            if (inst_en) begin
                valid_r[inst_set][inst_way] <= 1'b1;
                dirty_r[inst_set][inst_way] <= 1'b0;
                wt_r[inst_set][inst_way]    <= inst_wt;
            end
            if (dirty_en) begin
                dirty_r[dirty_set][dirty_way] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (inst_en) begin
            tag_r[inst_set][inst_way] <= inst_tag;
        end
    end

    assign way_valid = valid_r[rd_set];
    assign way_dirty = dirty_r[rd_set];
    assign way_wt    = wt_r[rd_set];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign way_tag[w] = tag_r[rd_set][w];
    end

    always_comb begin
        hit     = 1'b0;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (way_valid[w] && way_tag[w] == cmp_tag) begin
                hit     = 1'b1;
                hit_way = WAY_BITS'(w);
            end
        end
    end
endmodule

// File: rtl/lkc_data.sv
module lkc_data #(
    parameter int SETS   = 4,
    parameter int WAYS   = 2,
    parameter int BEATS  = 2,
    parameter int DATA_W = 128
) (
    input  logic                                 clk,
    input  logic [$clog2(SETS*WAYS*BEATS)-1:0]   rd_idx,
    output logic [DATA_W-1:0]                    rd_data,
    input  logic                                 we,
    input  logic [$clog2(SETS*WAYS*BEATS)-1:0]   wr_idx,
    input  logic [DATA_W-1:0]                    wr_data
);
    localparam int DEPTH = SETS * WAYS * BEATS;

    logic [DATA_W-1:0] arr [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            arr[wr_idx] <= wr_data;
        end
    end

    assign rd_data = arr[rd_idx];
endmodule

// File: rtl/lkc_victim.sv
module lkc_victim #(
    parameter int SETS = 4,
    parameter int WAYS = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [$clog2(SETS)-1:0]   set_i,
    input  logic [WAYS-1:0]           valid_i,
    output logic [$clog2(WAYS)-1:0]   way_o,
    input  logic                      adv_en,
    input  logic [$clog2(SETS)-1:0]   adv_set,
    input  logic [$clog2(WAYS)-1:0]   adv_way
);
    localparam int WAY_BITS = $clog2(WAYS);

    logic [WAY_BITS-1:0] rr_q [SETS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                rr_q[s] <= '0;
            end
        end else if (adv_en) begin
            rr_q[adv_set] <= adv_way + 1'b1;
        end
    end

    always_comb begin
        way_o = rr_q[set_i];
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_i[w]) begin
                way_o = WAY_BITS'(w);
            end
        end
    end
endmodule

// File: rtl/lkc_cache.sv
module lkc_cache
    import lkc_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 128,
    parameter int SETS   = 4,
    parameter int WAYS   = 2,
    parameter int BEATS  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_disable,
    input  logic              cfg_lock,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic              cpu_wt,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int BEAT_BITS = $clog2(BEATS);
    localparam int SET_BITS  = $clog2(SETS);
    localparam int WAY_BITS  = $clog2(WAYS);
    localparam int TAG_W     = ADDR_W - SET_BITS - BEAT_BITS;
    localparam int IDX_W     = SET_BITS + WAY_BITS + BEAT_BITS;

    lkc_state_e state, nstate;

    logic [ADDR_W-1:0]    addr_q;
    logic [DATA_W-1:0]    wdata_q, rdata_q;
    logic                 we_q, wt_q, dis_q, lock_q;
    logic [BEAT_BITS-1:0] beat_q;
    logic [WAY_BITS-1:0]  victim_q;

    logic [SET_BITS-1:0]  set_q;
    logic [TAG_W-1:0]     tag_q;
    logic [BEAT_BITS-1:0] beat_req;
    assign set_q    = addr_q[BEAT_BITS +: SET_BITS];
    assign tag_q    = addr_q[ADDR_W-1 -: TAG_W];
    assign beat_req = addr_q[BEAT_BITS-1:0];

    logic                         hit;
    logic [WAY_BITS-1:0]          hit_way, vic_way;
    logic [WAYS-1:0]              way_valid, way_dirty, way_wt;
    logic [WAYS-1:0][TAG_W-1:0]   way_tag;
    logic                         tag_install, dirty_set_en, data_we;
    logic [DATA_W-1:0]            arr_rdata;
    logic [IDX_W-1:0]             rd_idx, wr_idx;

    lkc_tags #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .rd_set(set_q), .cmp_tag(tag_q),
        .hit(hit), .hit_way(hit_way), .way_valid(way_valid),
        .way_dirty(way_dirty), .way_wt(way_wt), .way_tag(way_tag),
        .inst_en(tag_install), .inst_set(set_q), .inst_way(victim_q),
        .inst_tag(tag_q), .inst_wt(wt_q),
        .dirty_en(dirty_set_en), .dirty_set(set_q), .dirty_way(hit_way)
    );

    lkc_victim #(.SETS(SETS), .WAYS(WAYS)) u_victim (
        .clk(clk), .rst_n(rst_n), .set_i(set_q), .valid_i(way_valid),
        .way_o(vic_way), .adv_en(tag_install), .adv_set(set_q),
        .adv_way(victim_q)
    );

    assign rd_idx = (state == ST_WBACK) ? {set_q, victim_q, beat_q}
                                        : {set_q, hit_way, beat_req};
    assign wr_idx = (state == ST_FILL)  ? {set_q, victim_q, beat_q}
                                        : {set_q, hit_way, beat_req};

    lkc_data #(.SETS(SETS), .WAYS(WAYS), .BEATS(BEATS), .DATA_W(DATA_W)) u_data (
        .clk(clk), .rd_idx(rd_idx), .rd_data(arr_rdata), .we(data_we),
        .wr_idx(wr_idx),
        .wr_data((state == ST_FILL) ? mem_rdata : wdata_q)
    );

    logic hit_wt, vic_needs_wb, last_beat;
    assign hit_wt       = way_wt[hit_way];
    assign vic_needs_wb = way_valid[vic_way] & way_dirty[vic_way];
    assign last_beat    = (beat_q == BEAT_BITS'(BEATS - 1));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // Next state and outputs
    always_comb begin
        nstate       = state;
        data_we      = 1'b0;
        tag_install  = 1'b0;
        dirty_set_en = 1'b0;
        mem_req      = 1'b0;
        mem_we       = 1'b0;
        mem_addr     = addr_q;
        mem_wdata    = wdata_q;
        cpu_ready    = 1'b0;
        unique case (state)
            ST_IDLE: if (cpu_req) nstate = ST_LOOKUP;
            ST_LOOKUP: begin
                if (dis_q) begin
                    nstate = we_q ? ST_MEMWR : ST_MEMRD;
                end else if (hit) begin
                    if (we_q) begin
                        data_we = 1'b1;
                        if (hit_wt) begin
                            nstate = ST_MEMWR;
                        end else begin
                            dirty_set_en = 1'b1;
                            nstate       = ST_DONE;
                        end
                    end else begin
                        nstate = ST_DONE;
                    end
                end else if (lock_q) begin
                    nstate = we_q ? ST_MEMWR : ST_MEMRD;
                end else begin
                    nstate = vic_needs_wb ? ST_WBACK : ST_FILL;
                end
            end
            ST_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {way_tag[victim_q], set_q, beat_q};
                mem_wdata = arr_rdata;
                if (mem_ack && last_beat) nstate = ST_FILL;
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {tag_q, set_q, beat_q};
                if (mem_ack) begin
                    data_we = 1'b1;
                    if (last_beat) begin
                        tag_install = 1'b1;
                        nstate      = ST_LOOKUP;
                    end
                end
            end
            ST_MEMWR: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ack) nstate = ST_DONE;
            end
            ST_MEMRD: begin
                mem_req = 1'b1;
                if (mem_ack) nstate = ST_DONE;
            end
            ST_DONE: begin
                cpu_ready = 1'b1;
                nstate    = ST_IDLE;
            end
            default: nstate = ST_IDLE;
        endcase
    end

    // Request and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            wdata_q  <= '0;
            rdata_q  <= '0;
            we_q     <= 1'b0;
            wt_q     <= 1'b0;
            dis_q    <= 1'b0;
            lock_q   <= 1'b0;
            beat_q   <= '0;
            victim_q <= '0;
        end else begin
            if (state == ST_IDLE && cpu_req) begin
                addr_q  <= cpu_addr;
                wdata_q <= cpu_wdata;
                we_q    <= cpu_we;
                wt_q    <= cpu_wt;
                dis_q   <= cfg_disable;
                lock_q  <= cfg_lock;
            end
            if (state == ST_LOOKUP) begin
                beat_q   <= '0;
                victim_q <= vic_way;
                if (!dis_q && hit && !we_q) rdata_q <= arr_rdata;
            end
            if ((state == ST_WBACK || state == ST_FILL) && mem_ack) begin
                beat_q <= beat_q + 1'b1;
            end
            if (state == ST_MEMRD && mem_ack) rdata_q <= mem_rdata;
        end
    end

    assign cpu_rdata = rdata_q;
endmodule

// File: rtl/lkc_cache_chk.sv
module lkc_cache_chk
    import lkc_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input lkc_state_e        state,
    input logic              dis_q,
    input logic              lock_q,
    input logic              data_we,
    input logic              tag_install,
    input logic              dirty_set_en,
    input logic              vic_needs_wb,
    input logic              cpu_ready,
    input logic              mem_req,
    input logic              mem_ack,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr
);
    assert_disable_no_array_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && dis_q) |-> !(data_we || tag_install || dirty_set_en));

    assert_lock_no_alloc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && lock_q && !dis_q) |-> !tag_install);

    assert_lock_no_evict_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && lock_q) |-> (state != ST_WBACK && state != ST_FILL));

    assert_wb_before_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL && $past(state) == ST_LOOKUP) |-> !$past(vic_needs_wb));

    assert_ready_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    assert_bus_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
endmodule

bind lkc_cache lkc_cache_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .dis_q(dis_q), .lock_q(lock_q),
    .data_we(data_we), .tag_install(tag_install), .dirty_set_en(dirty_set_en),
    .vic_needs_wb(vic_needs_wb), .cpu_ready(cpu_ready), .mem_req(mem_req),
    .mem_ack(mem_ack), .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/tb_lkc_cache.sv
module tb_lkc_cache;
    localparam int CLK_PERIOD = 10;
    localparam int MEMSZ = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_disable = 1'b0, cfg_lock = 1'b0;
    logic cpu_req = 1'b0, cpu_we = 1'b0, cpu_wt = 1'b0;
    logic [9:0] cpu_addr = '0;
    logic [127:0] cpu_wdata = '0;
    logic cpu_ready;
    logic [127:0] cpu_rdata;
    logic mem_req, mem_we;
    logic [9:0] mem_addr;
    logic [127:0] mem_wdata;
    logic mem_ack = 1'b0;
    logic [127:0] mem_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lkc_cache dut (
        .clk(clk), .rst_n(rst_n), .cfg_disable(cfg_disable), .cfg_lock(cfg_lock),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_wt(cpu_wt), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int nchk = 0, nfail = 0;
    int nrd = 0, nwr = 0, op_n = 0, viol = 0;
    logic [127:0] bmem  [MEMSZ];
    logic [127:0] ref_m [MEMSZ];
    logic         log_we   [256];
    logic [9:0]   log_addr [256];
    logic         pend = 1'b0;
    logic [9:0]   paddr = '0;
    logic         pwe = 1'b0;

    function automatic logic [127:0] pat(int i);
        return {32'(i) ^ 32'h1111_1111, ~32'(i), 32'(i) * 32'd3, 32'hC0DE_0000 + 32'(i)};
    endfunction

    function automatic logic [9:0] mk(int t, int s, int b);
        return 10'((t << 3) | (s << 1) | b);
    endfunction

    // Memory responder: answers one cycle after first seeing a request
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEMSZ; i++) bmem[i] <= pat(i);
            mem_ack <= 1'b0;
            pend    <= 1'b0;
        end else begin
            mem_ack <= 1'b0;
            if (mem_req && !mem_ack) begin
                if (!pend) begin
                    pend  <= 1'b1;
                    paddr <= mem_addr;
                    pwe   <= mem_we;
                end else begin
                    if (paddr != mem_addr || pwe != mem_we) viol <= viol + 1;
                    pend    <= 1'b0;
                    mem_ack <= 1'b1;
                    log_we[op_n[7:0]]   <= mem_we;
                    log_addr[op_n[7:0]] <= mem_addr;
                    op_n <= op_n + 1;
                    if (mem_we) begin
                        bmem[mem_addr] <= mem_wdata;
                        nwr <= nwr + 1;
                    end else begin
                        mem_rdata <= bmem[mem_addr];
                        nrd <= nrd + 1;
                    end
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input bit we, input logic [9:0] a, input logic [127:0] d,
                          input bit wt, output logic [127:0] rd);
        int n;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_wt = wt;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!cpu_ready && n < 2000);
        rd = cpu_rdata;
        cpu_req = 1'b0;
        if (we) ref_m[a] = d;
        @(negedge clk);
        check(!cpu_ready, "R8 ready pulse", 128'(cpu_ready), 128'd0);
    endtask

    task automatic do_rd(input logic [9:0] a, input bit wt, input int er, input int ew, input string req);
        int r0, w0;
        logic [127:0] rd;
        r0 = nrd; w0 = nwr;
        access(1'b0, a, '0, wt, rd);
        check(rd === ref_m[a], {req, " load data"}, rd, ref_m[a]);
        check(nrd - r0 == er && nwr - w0 == ew, {req, " bus reads/writes"},
              128'((nrd - r0) * 100 + (nwr - w0)), 128'(er * 100 + ew));
    endtask

    task automatic do_wr(input logic [9:0] a, input logic [127:0] d, input bit wt,
                         input int er, input int ew, input string req);
        int r0, w0;
        logic [127:0] rd;
        r0 = nrd; w0 = nwr;
        access(1'b1, a, d, wt, rd);
        check(nrd - r0 == er && nwr - w0 == ew, {req, " bus reads/writes"},
              128'((nrd - r0) * 100 + (nwr - w0)), 128'(er * 100 + ew));
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(!cpu_ready && !mem_req, "R10 reset outputs", 128'({cpu_ready, mem_req}), 128'd0);
    endtask

    task automatic t_disable();
        logic [9:0] a, b;
        a = mk(5, 0, 0); b = mk(5, 0, 1);
        cfg_disable = 1'b1; cfg_lock = 1'b0;
        do_wr(a, 128'hD1D1, 1'b0, 0, 1, "R1 bypass write wb");
        check(bmem[a] === 128'hD1D1, "R1 bypass write reaches memory", bmem[a], 128'hD1D1);
        do_rd(a, 1'b0, 1, 0, "R1 bypass read");
        cfg_lock = 1'b1;
        do_wr(b, 128'hD2D2, 1'b1, 0, 1, "R1 bypass write wt locked");
        do_rd(b, 1'b1, 1, 0, "R1 bypass read locked");
        cfg_disable = 1'b0; cfg_lock = 1'b0;
        do_rd(a, 1'b0, 2, 0, "R1 R10 R11 arrays untouched then fill");
        do_rd(b, 1'b0, 0, 0, "R11 second beat hits");
    endtask

    task automatic t_writeback();
        logic [9:0] x;
        int s;
        x = mk(1, 1, 0);
        do_wr(x, 128'hD3D3, 1'b0, 2, 0, "R3 R11 write miss allocates wb");
        check(bmem[x] === pat(x), "R3 memory keeps old value", bmem[x], pat(x));
        do_wr(x + 10'd1, 128'hD4D4, 1'b1, 0, 0, "R4 stored wb ignores wt attribute");
        do_rd(mk(2, 1, 0), 1'b0, 2, 0, "R7 invalid way filled first");
        s = op_n;
        do_rd(mk(3, 1, 1), 1'b0, 2, 2, "R5 dirty eviction");
        check(log_we[s[7:0]] && log_we[8'(s + 1)] && !log_we[8'(s + 2)] && !log_we[8'(s + 3)],
              "R5 writes before refill",
              128'({log_we[s[7:0]], log_we[8'(s + 1)], log_we[8'(s + 2)], log_we[8'(s + 3)]}),
              128'b1100);
        check(log_addr[s[7:0]] == x && log_addr[8'(s + 1)] == x + 10'd1, "R5 beat order",
              128'({log_addr[s[7:0]], log_addr[8'(s + 1)]}), 128'({x, x + 10'd1}));
        check(bmem[x] === 128'hD3D3 && bmem[x + 10'd1] === 128'hD4D4, "R3 line written back",
              bmem[x], 128'hD3D3);
        do_rd(mk(4, 1, 0), 1'b0, 2, 0, "R7 round-robin evicts clean way 1");
        do_rd(mk(3, 1, 0), 1'b0, 0, 0, "R7 way 0 kept");
        do_rd(mk(4, 1, 1), 1'b0, 0, 0, "R7 way 1 hit");
        do_rd(x, 1'b0, 2, 0, "R3 refetch after writeback");
    endtask

    task automatic t_writethrough();
        logic [9:0] y, w;
        y = mk(1, 2, 0); w = mk(6, 2, 1);
        do_rd(y, 1'b1, 2, 0, "R11 read miss fills wt line");
        do_wr(y, 128'hD5D5, 1'b0, 0, 1, "R2 R4 wt hit writes memory");
        check(bmem[y] === 128'hD5D5, "R2 memory updated", bmem[y], 128'hD5D5);
        do_rd(y, 1'b0, 0, 0, "R2 array updated");
        do_rd(mk(2, 2, 0), 1'b0, 2, 0, "R7 fill way 1");
        do_rd(mk(3, 2, 0), 1'b0, 2, 0, "R2 clean eviction no writeback");
        do_wr(w, 128'hD6D6, 1'b1, 2, 1, "R11 write miss allocates wt");
        check(bmem[w] === 128'hD6D6, "R11 wt write miss reaches memory", bmem[w], 128'hD6D6);
        do_rd(y, 1'b0, 2, 0, "R2 refetch gets written value");
    endtask

    task automatic t_lock();
        logic [9:0] z1, z2, z3;
        z1 = mk(1, 3, 0); z2 = mk(2, 3, 0); z3 = mk(3, 3, 1);
        do_rd(z1, 1'b0, 2, 0, "R11 fill before lock");
        do_wr(z1, 128'hD7D7, 1'b0, 0, 0, "R3 wb hit before lock");
        cfg_lock = 1'b1;
        do_rd(z1, 1'b0, 0, 0, "R6 locked read hit");
        do_wr(z1 + 10'd1, 128'hD8D8, 1'b0, 0, 0, "R6 locked write hit");
        do_rd(z2, 1'b0, 1, 0, "R6 locked read miss single beat");
        do_rd(z2, 1'b0, 1, 0, "R6 R7 locked miss not allocated");
        do_wr(z3, 128'hD9D9, 1'b1, 0, 1, "R6 locked write miss forwarded");
        check(bmem[z3] === 128'hD9D9, "R6 forwarded write in memory", bmem[z3], 128'hD9D9);
        do_rd(z3, 1'b0, 1, 0, "R6 locked read of forwarded write");
        do_rd(z1, 1'b0, 0, 0, "R6 no eviction while locked");
        do_rd(z1 + 10'd1, 1'b0, 0, 0, "R6 locked hit data kept");
        cfg_lock = 1'b0;
        do_rd(z2, 1'b0, 2, 0, "R7 allocation resumes after unlock");
        do_rd(z1, 1'b0, 0, 0, "R7 dirty line kept in way 0");
    endtask

    initial begin
        for (int i = 0; i < MEMSZ; i++) ref_m[i] = pat(i);
        repeat (4) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_disable();
        t_writeback();
        t_writethrough();
        t_lock();
        check(viol == 0, "R9 bus request held stable", 128'(viol), 128'd0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule